// File: doc/BRIEF.md
# Load/Store Address Generator

This block turns the decoded fields of a single-register load or store into a memory access. It takes the base register value and index, an offset that is either an immediate or already shifted, and flags for indexing order, offset direction, base update, direction of transfer, access size and signedness. From these it works out the access address and the store data lanes, and decides whether the base register is rewritten and with what value. It raises a one-cycle error flag for flag combinations that are not legal, but still issues the access.

Each accepted request appears on the memory side one clock later as a single-cycle request strobe. A load's data comes back on a response strobe. The block widens that data to 32 bits as the access size and signedness require, and presents it one clock after the response. When the base or the store data register is the program counter, the address is adjusted to account for the pipeline reading ahead.

Top module: `ls_agu`

## Requirements
- R1: After reset, `mem_req`, `wb_en`, `err` and `ld_valid` are low.
- R2: A request with `req_valid` high produces `mem_req` high on the next cycle. With `pre_idx`=1 the address is the effective base moved by the offset. With `pre_idx`=0 it is the unmodified effective base.
- R3: `add_off`=1 adds the offset to the base and `add_off`=0 subtracts it. This applies to both the address and the writeback value.
- R4: `wb_en` is high when `pre_idx`=0 or `wb_req`=1. `wb_val` is always the effective base moved by the offset, and never includes the store correction of R6.
- R5: When `base_idx` is 15, the effective base is `base_val` minus 8. This is used for both the address and the writeback value.
- R6: A store (`is_load`=0) whose `data_idx` is 15 has 4 added to its access address.
- R7: `mem_we` is the inverse of `is_load`. `size` 2'b01 (byte) drives only `store_val[7:0]`, with the upper bits zero. `size` 2'b10 (halfword) drives only `store_val[15:0]`. `size` 2'b00 (word) drives all 32 bits.
- R8: One cycle after `rsp_valid`, `ld_valid` is high and `ld_data` holds `rsp_data` widened as follows. A byte is taken from bit 7 down, and a halfword from bit 15 down. Each is sign-extended when `is_signed`=1 and zero-extended otherwise. A word passes through unchanged. The size and sign used are those of the most recently issued access.
- R9: `err` is high for exactly the cycle in which the access is presented when `pre_idx`=0 with `wb_req`=1, or when `is_signed`=1 on a store. The access is still issued.
- R10: In a cycle with no request pending, `mem_req`, `wb_en` and `err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe |
| base_val | input | 32 | Base register value |
| base_idx | input | 4 | Base register index |
| data_idx | input | 4 | Data register index |
| offset | input | 32 | Offset magnitude |
| pre_idx | input | 1 | 1: apply offset before access |
| add_off | input | 1 | 1: add offset, 0: subtract |
| wb_req | input | 1 | Base update requested |
| is_load | input | 1 | 1: load, 0: store |
| size | input | 2 | 00 word, 01 byte, 10 halfword |
| is_signed | input | 1 | Sign-extend load data |
| store_val | input | 32 | Data register value for stores |
| mem_req | output | 1 | Memory request strobe |
| mem_we | output | 1 | Write enable |
| mem_addr | output | 32 | Access address |
| mem_wdata | output | 32 | Store data lanes |
| rsp_valid | input | 1 | Memory response strobe |
| rsp_data | input | 32 | Memory response data |
| wb_en | output | 1 | Base writeback enable |
| wb_val | output | 32 | Base writeback value |
| err | output | 1 | Illegal flag combination |
| ld_valid | output | 1 | Load result strobe |
| ld_data | output | 32 | Extended load result |

## Verification
The access address, the store lanes, the write enable, the writeback pair and the error flag all come from one register stage. The bench drives a request on a falling edge and samples these outputs on the falling edge that follows the next rising edge. The load result passes through one register after the response, so the response is driven on a falling edge and `ld_data` is read one full cycle later. On that same later sample the bench also confirms that `err` and `mem_req` have dropped back.

// File: rtl/ls_agu.sv
module ls_agu #(
  parameter int DW = 32,
  parameter int RW = 4,
  parameter logic [RW-1:0] PC_IDX = '1,
  parameter int PC_AHEAD = 8,
  parameter int PC_STORE_ADV = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [DW-1:0] base_val,
  input  logic [RW-1:0] base_idx,
  input  logic [RW-1:0] data_idx,
  input  logic [DW-1:0] offset,
  input  logic          pre_idx,
  input  logic          add_off,
  input  logic          wb_req,
  input  logic          is_load,
  input  logic [1:0]    size,
  input  logic          is_signed,
  input  logic [DW-1:0] store_val,
  output logic          mem_req,
  output logic          mem_we,
  output logic [DW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic          rsp_valid,
  input  logic [DW-1:0] rsp_data,
  output logic          wb_en,
  output logic [DW-1:0] wb_val,
  output logic          err,
  output logic          ld_valid,
  output logic [DW-1:0] ld_data
);
  localparam logic [1:0] SZ_WORD = 2'b00;
  localparam logic [1:0] SZ_BYTE = 2'b01;
  localparam logic [1:0] SZ_HALF = 2'b10;

  logic [DW-1:0] base_eff, moved, acc_addr, lanes, widened;
  logic [1:0]    sz_q, ld_sz_q;
  logic          sgn_q, ld_sgn_q;

  assign base_eff = base_val - ((base_idx == PC_IDX) ? DW'(PC_AHEAD) : '0);
  assign moved    = add_off ? base_eff + offset : base_eff - offset;
  assign acc_addr = (pre_idx ? moved : base_eff)
                  + ((!is_load && data_idx == PC_IDX) ? DW'(PC_STORE_ADV) : '0);

  always_comb begin
    case (size)
      SZ_BYTE: lanes = {{(DW-8){1'b0}},  store_val[7:0]};
      SZ_HALF: lanes = {{(DW-16){1'b0}}, store_val[15:0]};
      default: lanes = store_val;
    endcase
  end

  always_comb begin
    case (sz_q)
      SZ_BYTE: widened = {{(DW-8){sgn_q & rsp_data[7]}},   rsp_data[7:0]};
      SZ_HALF: widened = {{(DW-16){sgn_q & rsp_data[15]}}, rsp_data[15:0]};
      default: widened = rsp_data;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mem_req   <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      wb_en     <= 1'b0;
      wb_val    <= '0;
      err       <= 1'b0;
      sz_q      <= SZ_WORD;
      sgn_q     <= 1'b0;
      ld_valid  <= 1'b0;
      ld_data   <= '0;
      ld_sz_q   <= SZ_WORD;
      ld_sgn_q  <= 1'b0;
    end else begin
      mem_req  <= req_valid;
      wb_en    <= req_valid & (!pre_idx | wb_req);
      err      <= req_valid & ((!pre_idx & wb_req) | (is_signed & !is_load));
      if (req_valid) begin
        mem_we    <= !is_load;
        mem_addr  <= acc_addr;
        mem_wdata <= lanes;
        wb_val    <= moved;
        sz_q      <= size;
        sgn_q     <= is_signed;
      end
      ld_valid <= rsp_valid;
      if (rsp_valid) begin
        ld_data  <= widened;
        ld_sz_q  <= sz_q;
        ld_sgn_q <= sgn_q;
      end
    end
  end

  // R2
  issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> mem_req);
  // R9
  err_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> mem_req);
  // R10
  idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_req |-> (!wb_en && !err));
  // R8
  ldv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> ld_valid);
  // R7
  byte_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we && sz_q == SZ_BYTE) |-> (mem_wdata[DW-1:8] == '0));
  // R8
  sext_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_valid && ld_sgn_q && ld_sz_q == SZ_BYTE) |->
      ($countones(ld_data[DW-1:7]) == 0 || $countones(ld_data[DW-1:7]) == DW-7));
endmodule

// File: tb/sim_ls_agu.sv
module sim_ls_agu;
  logic clk = 0;
  always #10 clk = ~clk;

  logic rst_n, req_valid, pre_idx, add_off, wb_req, is_load, is_signed, rsp_valid;
  logic [31:0] base_val, offset, store_val, rsp_data;
  logic [3:0] base_idx, data_idx;
  logic [1:0] size;
  logic mem_req, mem_we, wb_en, err, ld_valid;
  logic [31:0] mem_addr, mem_wdata, wb_val, ld_data;

  ls_agu u0 (.clk(clk), .rst_n(rst_n), .req_valid(req_valid), .base_val(base_val),
    .base_idx(base_idx), .data_idx(data_idx), .offset(offset), .pre_idx(pre_idx),
    .add_off(add_off), .wb_req(wb_req), .is_load(is_load), .size(size),
    .is_signed(is_signed), .store_val(store_val), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .wb_en(wb_en), .wb_val(wb_val), .err(err), .ld_valid(ld_valid), .ld_data(ld_data));

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // {base, offset, base_idx, data_idx, pre, up, wb, ld, sgn, size[1:0], pad}
  localparam int NV = 10;
  localparam logic [79:0] TAB [NV] = '{
    {32'h1000, 32'h10, 4'd2,  4'd3,  8'b1_1_0_1_0_00_0},
    {32'h1000, 32'h10, 4'd2,  4'd3,  8'b1_0_1_1_1_01_0},
    {32'h2000, 32'h24, 4'd4,  4'd5,  8'b0_1_0_0_0_01_0},
    {32'h2000, 32'h24, 4'd4,  4'd5,  8'b0_0_1_1_0_10_0},
    {32'h0108, 32'h04, 4'd15, 4'd1,  8'b1_1_0_1_0_00_0},
    {32'h0300, 32'h08, 4'd6,  4'd15, 8'b1_1_1_0_0_00_0},
    {32'h0400, 32'h02, 4'd7,  4'd8,  8'b1_1_0_0_1_10_0},
    {32'h0208, 32'h10, 4'd15, 4'd15, 8'b0_1_0_0_0_01_0},
    {32'h0500, 32'h06, 4'd9,  4'd2,  8'b1_1_0_1_1_10_0},
    {32'h0600, 32'h01, 4'd9,  4'd2,  8'b1_1_0_1_0_01_0}
  };
  localparam logic [31:0] SVAL = 32'hA5C3_F18E;
  localparam logic [31:0] RSP  = 32'h8001_80F7;

  task automatic run_op(logic [79:0] v, logic [31:0] rsp);
    logic [31:0] b, moved, ea, ewd, eld;
    logic pre, up, wb, ld, sg;
    logic [1:0] sz;
    {base_val, offset, base_idx, data_idx, pre, up, wb, ld, sg, sz} = v[79:1];
    pre_idx = pre; add_off = up; wb_req = wb; is_load = ld; is_signed = sg; size = sz;
    store_val = SVAL; req_valid = 1;
    b = base_val - ((base_idx == 4'd15) ? 32'd8 : 32'd0);               // R5
    moved = up ? b + offset : b - offset;                                // R3
    ea = (pre ? moved : b) + ((!ld && data_idx == 4'd15) ? 32'd4 : 0);  // R2 R6
    ewd = (sz == 2'b01) ? {24'h0, SVAL[7:0]} : (sz == 2'b10) ? {16'h0, SVAL[15:0]} : SVAL;
    if (sz == 2'b01) eld = {{24{sg & rsp[7]}}, rsp[7:0]};
    else if (sz == 2'b10) eld = {{16{sg & rsp[15]}}, rsp[15:0]};
    else eld = rsp;
    @(posedge clk); @(negedge clk);
    req_valid = 0;
    chk("R2 mem_req", {31'b0, mem_req}, 1);
    chk("R2/R5/R6 mem_addr", mem_addr, ea);
    chk("R7 mem_we", {31'b0, mem_we}, {31'b0, !ld});
    if (!ld) chk("R7 mem_wdata", mem_wdata, ewd);
    chk("R4 wb_en", {31'b0, wb_en}, {31'b0, !pre | wb});
    chk("R4/R3 wb_val", wb_val, moved);
    chk("R9 err", {31'b0, err}, {31'b0, (!pre & wb) | (sg & !ld)});
    rsp_valid = ld; rsp_data = rsp;
    @(posedge clk); @(negedge clk);
    rsp_valid = 0;
    chk("R9 err pulse ends", {31'b0, err}, 0);
    chk("R10 mem_req idle", {31'b0, mem_req}, 0);
    chk("R10 wb_en idle", {31'b0, wb_en}, 0);
    if (ld) begin
      chk("R8 ld_valid", {31'b0, ld_valid}, 1);
      chk("R8 ld_data", ld_data, eld);
    end
  endtask

  initial begin
    rst_n = 0; req_valid = 0; rsp_valid = 0; base_val = 0; offset = 0; base_idx = 0;
    data_idx = 0; pre_idx = 0; add_off = 0; wb_req = 0; is_load = 0; size = 0;
    is_signed = 0; store_val = 0; rsp_data = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 mem_req", {31'b0, mem_req}, 0);
    chk("R1 wb_en", {31'b0, wb_en}, 0);
    chk("R1 err", {31'b0, err}, 0);
    chk("R1 ld_valid", {31'b0, ld_valid}, 0);
    rst_n = 1;
    for (int i = 0; i < NV; i++) run_op(TAB[i], RSP);
    // R8 positive signed halfword and word passthrough
    run_op({32'h700, 32'h0, 4'd1, 4'd2, 8'b1_1_0_1_1_10_0}, 32'hFFFF_7F70);
    run_op({32'h700, 32'h0, 4'd1, 4'd2, 8'b1_1_0_1_1_00_0}, 32'hFFFF_7F70);
    // R9 both illegal conditions together
    run_op({32'h800, 32'h4, 4'd1, 4'd2, 8'b0_1_1_0_1_10_0}, RSP);
    // R10 idle for several cycles
    repeat (3) @(negedge clk);
    chk("R10 idle mem_req", {31'b0, mem_req}, 0);
    chk("R10 idle ld_valid", {31'b0, ld_valid}, 0);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog act=hung exp=done");
      end
    join_any
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule